// File: doc/BRIEF.md
# Fan Controller Interrupt Aggregator

This block gathers the status conditions of a temperature and fan monitor and turns them into two active-low outputs: a shared alert line that tells a host something needs attention, and a thermal output that can drive an external fan or system throttle directly. Eight raw conditions come in: local and remote thermal limit, local and remote over-temperature, remote sensor failure, low supply, fan stall and RPM alarm. Each is caught on its rising edge into a sticky flag. The flag stays set until the host clears it with a per-flag clear strobe while the condition itself has gone away.

A small enable register decides which flags may reach the alert line. The host loads it with a single write strobe. One enable covers both thermal-limit flags and one covers both fan flags. The four remaining sources each have their own enable. A global enable gates everything bound for the alert line. When the thermal enable is off, the thermal-limit flags are not dropped. They are sent to the thermal output instead of the alert line. Both outputs are registered so that they cannot glitch.

Top module: `fan_alert_combiner`

## Requirements
- R1: A rising edge of a condition bit sets the matching flag bit, which shows on `flagState` after the first clock edge that samples the condition high. The flag stays set for as long as the condition stays high. The condition and flag bit order is: 0 local thermal limit, 1 remote thermal limit, 2 local over-temperature, 3 remote over-temperature, 4 remote sensor failure, 5 low supply, 6 fan stall, 7 RPM alarm.
- R2: A clear strobe bit clears its flag on the next edge only when the matching condition is low. While the condition is high, the clear has no effect.
- R3: With the thermal enable (enable bit 0) set, a set thermal-limit flag (flag 0 or 1) drives `alertN` low, provided the global enable is set.
- R4: With the thermal enable clear, a set thermal-limit flag drives `thermN` low and does not affect `alertN`. With the thermal enable set, `thermN` stays high.
- R5: The fan stall and RPM alarm flags (6, 7) reach `alertN` only while the fan enable (enable bit 1) is set.
- R6: Remote over-temperature (enable bit 2), local over-temperature (bit 3), sensor failure (bit 4) and low supply (bit 5) each reach `alertN` only while their own enable is set.
- R7: While the global enable (enable bit 6) is clear, `alertN` is high whatever the flags are.
- R8: During reset all flags clear and `alertN` and `thermN` go high. The enable register takes the value 7'b0011111, except that bit 2 is 0 when the remote sensor failure condition is high during reset.
- R9: `alertN` and `thermN` are registered. They reflect the flags and enables held before the clock edge, one edge after the flag is set.
- R10: When `enWr` is high at an edge, `enState` takes the value of `enWrData` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| condIn | input | 8 | Raw status conditions, bit order as in R1 |
| clrIn | input | 8 | Per-flag clear strobes |
| enWr | input | 1 | Enable register load strobe |
| enWrData | input | 7 | New enable register value |
| enState | output | 7 | Current enable register |
| flagState | output | 8 | Sticky flags |
| alertN | output | 1 | Active-low combined alert |
| thermN | output | 1 | Active-low thermal output |

## Verification
The source count and the enable layout are fixed by the package, so the bench builds the block with its single default configuration. All eight sources and all seven enable bits are therefore reachable in one build. Random enable loads, sparse condition toggles and clear strobes drive every routing of a thermal flag, including the divert to `thermN` and the global gate. A bench model compares the outputs every cycle. Directed cases cover the two reset defaults and a clear issued while its condition is still active.

// File: rtl/fan_alert_pkg.sv
package fan_alert_pkg;
  localparam int NUM_SRC = 8;
  localparam int NUM_EN  = 7;

  // enable register bit positions
  localparam int EN_THERM  = 0;
  localparam int EN_FAN    = 1;
  localparam int EN_OT_REM = 2;
  localparam int EN_OT_LOC = 3;
  localparam int EN_FAIL   = 4;
  localparam int EN_LOWSUP = 5;
  localparam int EN_GLOBAL = 6;

  // source bit positions
  localparam int SRC_THERM_LOC = 0;
  localparam int SRC_THERM_REM = 1;
  localparam int SRC_OT_LOC    = 2;
  localparam int SRC_OT_REM    = 3;
  localparam int SRC_FAIL      = 4;
  localparam int SRC_LOWSUP    = 5;
  localparam int SRC_STALL     = 6;
  localparam int SRC_RPM       = 7;

  // reset value of the enable register before the sensor-failure override
  localparam logic [NUM_EN-1:0] EN_RESET = 7'b0011111;

  typedef struct packed {
    logic [NUM_SRC-1:0] srcMask;
    logic [NUM_SRC-1:0] clrMask;
    logic               thermDivert;
    logic               globalOn;
  } ctrl_strobes_t;

  function automatic int enIndexOf(input int src);
    case (src)
      SRC_THERM_LOC, SRC_THERM_REM: return EN_THERM;
      SRC_OT_LOC:                   return EN_OT_LOC;
      SRC_OT_REM:                   return EN_OT_REM;
      SRC_FAIL:                     return EN_FAIL;
      SRC_LOWSUP:                   return EN_LOWSUP;
      default:                      return EN_FAN;
    endcase
  endfunction
endpackage

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import fan_alert_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enWr,
  input  logic [NUM_EN-1:0]  enWrData,
  input  logic [NUM_SRC-1:0] clrIn,
  input  logic               remoteFailNow,
  output logic [NUM_EN-1:0]  enState,
  output ctrl_strobes_t      strobes
);
  logic [NUM_EN-1:0] enReg;
  logic [NUM_EN-1:0] enResetVal;

  always_comb begin
    enResetVal = EN_RESET;
    enResetVal[EN_OT_REM] = ~remoteFailNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)     enReg <= enResetVal;
    else if (enWr) enReg <= enWrData;
  end

  logic [NUM_SRC-1:0] mask;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    assign mask[i] = enReg[enIndexOf(i)];
  end

  always_comb begin
    strobes.srcMask     = mask;
    strobes.clrMask     = clrIn;
    strobes.thermDivert = ~enReg[EN_THERM];
    strobes.globalOn    = enReg[EN_GLOBAL];
  end

  assign enState = enReg;

  // R10: a load takes effect on the next edge
  p_en_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    enWr |=> enState == $past(enWrData));

  // R8: reset value with the remote over-temperature override
  p_reset_default_r8: assert property (@(posedge clk)
    !rstN |=> (enState[EN_GLOBAL] == 1'b0) && (enState[EN_LOWSUP] == 1'b0)
              && (enState[EN_OT_REM] == ~$past(remoteFailNow)));
endmodule

// File: rtl/alert_datapath.sv
module alert_datapath
  import fan_alert_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] condIn,
  input  ctrl_strobes_t      strobes,
  output logic [NUM_SRC-1:0] flags,
  output logic               alertN,
  output logic               thermN
);
  logic [NUM_SRC-1:0] condPrev;
  logic [NUM_SRC-1:0] flagsNext;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_comb
      flagsNext[i] = (condIn[i] & ~condPrev[i]) |
                     (flags[i] & ~(strobes.clrMask[i] & ~condIn[i]));
  end

  logic thermHit;
  logic alertHit;
  assign thermHit = flags[SRC_THERM_LOC] | flags[SRC_THERM_REM];
  assign alertHit = strobes.globalOn & (|(flags & strobes.srcMask));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condPrev <= '0;
      flags    <= '0;
      alertN   <= 1'b1;
      thermN   <= 1'b1;
    end else begin
      condPrev <= condIn;
      flags    <= flagsNext;
      alertN   <= ~alertHit;
      thermN   <= ~(strobes.thermDivert & thermHit);
    end
  end

  // R7: global enable off keeps the alert released
  p_global_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.globalOn |=> alertN);

  // R4: diverted thermal flag pulls the thermal output
  p_therm_divert_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.thermDivert && thermHit) |=> !thermN);

  // R4: thermal output idle while the thermal enable is set
  p_therm_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.thermDivert |=> thermN);

  // R2: a flag whose condition is still high survives any clear
  p_clear_blocked_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((flags & condIn) != '0) |=> ((flags & $past(flags & condIn)) == $past(flags & condIn)));
endmodule

// File: rtl/fan_alert_combiner.sv
module fan_alert_combiner
  import fan_alert_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] condIn,
  input  logic [NUM_SRC-1:0] clrIn,
  input  logic               enWr,
  input  logic [NUM_EN-1:0]  enWrData,
  output logic [NUM_EN-1:0]  enState,
  output logic [NUM_SRC-1:0] flagState,
  output logic               alertN,
  output logic               thermN
);
  ctrl_strobes_t strobes;

  alert_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enWr          (enWr),
    .enWrData      (enWrData),
    .clrIn         (clrIn),
    .remoteFailNow (condIn[SRC_FAIL]),
    .enState       (enState),
    .strobes       (strobes)
  );

  alert_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .condIn  (condIn),
    .strobes (strobes),
    .flags   (flagState),
    .alertN  (alertN),
    .thermN  (thermN)
  );
endmodule

// File: tb/fan_alert_combiner_tb.sv
module fan_alert_combiner_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] condIn = '0;
  logic [7:0] clrIn = '0;
  logic enWr = 1'b0;
  logic [6:0] enWrData = '0;
  logic [6:0] enState;
  logic [7:0] flagState;
  logic alertN, thermN;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [7:0] mFlags = '0, mPrev = '0;
  logic [6:0] mEn = 7'h1F;
  logic mAlertN = 1'b1, mThermN = 1'b1;

  always #2 clk = ~clk;

  fan_alert_combiner u_dut (
    .clk(clk), .rstN(rstN), .condIn(condIn), .clrIn(clrIn), .enWr(enWr),
    .enWrData(enWrData), .enState(enState), .flagState(flagState),
    .alertN(alertN), .thermN(thermN)
  );

  function automatic logic [7:0] maskOf(input logic [6:0] e);
    return {e[1], e[1], e[5], e[4], e[2], e[3], e[0], e[0]};
  endfunction

  task automatic modelEdge();
    logic [7:0] rise;
    if (!rstN) begin
      mEn = 7'b0011111;
      mEn[2] = ~condIn[4];
      mFlags = '0; mPrev = '0; mAlertN = 1'b1; mThermN = 1'b1;
    end else begin
      mAlertN = ~(mEn[6] & (|(mFlags & maskOf(mEn))));
      mThermN = ~(~mEn[0] & (mFlags[0] | mFlags[1]));
      rise = condIn & ~mPrev;
      mFlags = rise | (mFlags & ~(clrIn & ~condIn));
      mPrev = condIn;
      if (enWr) mEn = enWrData;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    #1;
    chk(tag, "flagState", flagState, mFlags);
    chk(tag, "enState", {1'b0, enState}, {1'b0, mEn});
    chk(tag, "alertN", {7'b0, alertN}, {7'b0, mAlertN});
    chk(tag, "thermN", {7'b0, thermN}, {7'b0, mThermN});
    @(negedge clk);
    clrIn = '0;
    enWr = 1'b0;
  endtask

  task automatic loadEn(input logic [6:0] v, input string tag);
    enWr = 1'b1; enWrData = v;
    step(tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R8: plain reset defaults
    rstN = 1'b0; step("R8"); step("R8");
    rstN = 1'b1; step("R8");
    // R8: sensor failure present during reset
    rstN = 1'b0; condIn = 8'h10; step("R8"); step("R8");
    rstN = 1'b1; condIn = 8'h00; step("R8");
    // R10: enable load
    loadEn(7'h7F, "R10"); step("R10");
    // R1 and R6: remote over-temperature
    condIn[3] = 1'b1; step("R1"); step("R6"); step("R6");
    // R2: clear while active is ignored, then honoured after the condition drops
    clrIn[3] = 1'b1; step("R2"); step("R2");
    condIn[3] = 1'b0; clrIn[3] = 1'b1; step("R2"); step("R2");
    // R6: own enable off blocks the source
    loadEn(7'h7F & ~7'h04, "R6"); condIn[3] = 1'b1; step("R6"); step("R6"); step("R6");
    condIn[3] = 1'b0; clrIn[3] = 1'b1; step("R6"); step("R6");
    // R3: thermal-limit to alert
    loadEn(7'h7F, "R3"); condIn[0] = 1'b1; step("R3"); step("R3"); step("R3");
    // R4: thermal enable off diverts to thermN
    loadEn(7'h7E, "R4"); step("R4"); step("R4");
    condIn[0] = 1'b0; clrIn[0] = 1'b1; step("R4"); step("R4");
    // R5: fan flags gated by fan enable
    loadEn(7'h7D, "R5"); condIn[6] = 1'b1; step("R5"); step("R5"); step("R5");
    loadEn(7'h7F, "R5"); step("R5"); step("R5");
    // R7: global enable off
    loadEn(7'h3F, "R7"); step("R7"); step("R7");
    condIn[6] = 1'b0; clrIn = 8'hFF; step("R7"); step("R7");
    // R9: random traffic checked cycle by cycle
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 8; b++)
        if ($urandom_range(7) == 0) condIn[b] = ~condIn[b];
      clrIn = 8'($urandom) & 8'($urandom);
      if ($urandom_range(15) == 0) begin
        enWr = 1'b1;
        enWrData = 7'($urandom);
        if ($urandom_range(3) != 0) enWrData[6] = 1'b1;
      end
      if ($urandom_range(999) == 0) rstN = 1'b0;
      step("R9");
      rstN = 1'b1;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule